// File: doc/BRIEF.md
# Unified Issue Window and Reorder Buffer

This block keeps every in-flight instruction of an out-of-order core in a single circular buffer. That one buffer serves both as the pool of reservation stations and as the reorder buffer. Decoded instructions enter at the tail, and the index of the slot they land in serves as their tag. At entry the block resolves each source operand. The operand is taken from the architectural register file, from a finished but not yet retired producer in the buffer, or from the result bus in that same cycle. If none of these has it, the entry records the producer's tag. Pending operands are later captured by snooping the result bus.

Dispatch is decoupled from issue. Any free slot takes any instruction class. Each cycle the block offers the oldest ready adder-class entry to the adder, and the oldest ready multiplier-class entry to whichever multiplier reports itself free, so the unit is bound only at dispatch. Both classes may start an operation in the same cycle. Finished entries retire strictly in program order from the head and write the register file through the commit port. The per-register producer tag is then cleared, but only if no younger instruction has since claimed that register.

Top module: `unified_rs_rob`

## Requirements
- R1: The buffer holds 8 entries. `iss_ready` is low exactly when 8 instructions are in flight. `iss_tag` shows the slot the next accepted instruction takes, and successive accepted instructions get tags 0,1,…,7,0,… in order.
- R2: An issue request made while `iss_ready` is low is ignored. No entry is created, the tag sequence is unchanged, and no later dispatch or commit reflects it.
- R3: An accepted instruction becomes the pending producer of its destination register. A later reader of that register receives the producer's result. On commit, the pending mark is cleared only if it still names the committing entry, so a younger writer's value is never replaced by an older one.
- R4: At issue, a source whose register has no pending producer takes the register file value. A source whose producer has finished takes the producer's buffered result. A source whose producer's tag is on the result bus in that cycle takes `rb_data`.
- R5: A waiting operand is captured when its producer's tag appears with `rb_valid` high. The entry may dispatch no earlier than the next cycle. A newly issued entry may dispatch no earlier than the cycle after issue.
- R6: Acceptance depends only on occupancy, never on the classes (`iss_cls` 0 = adder class, 1 = multiplier class) of the entries in flight.
- R7: In any cycle with `add_free` high, `add_go` rises combinationally for the ready adder-class entry nearest the head that has not been dispatched, and presents its tag and operand values. Only one adder dispatch happens per cycle, and it may coincide with a multiplier dispatch.
- R8: The multiplier is picked at dispatch. `mul_go` is one-hot on the lowest-numbered unit whose `mul_free` bit is high. It is used for the ready multiplier-class entry nearest the head, and it is all-zero when no multiplier is free or no such entry is ready.
- R9: `commit_valid` is high when the head entry has received its result, at the earliest in the cycle after the broadcast. At most one entry retires per cycle, in tag order, giving its tag, destination and result.
- R10: After reset the buffer is empty, no dispatch or commit is signalled, the first tag is 0, and architectural register r holds the value r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Buffer can accept an instruction |
| iss_cls | input | 1 | Instruction class: 0 adder, 1 multiplier |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_dst | input | 3 | Destination register |
| iss_tag | output | 3 | Tag the next accepted instruction receives |
| rb_valid | input | 1 | Result bus carries a result |
| rb_tag | input | 3 | Tag of the broadcast result |
| rb_data | input | 16 | Broadcast result value |
| add_free | input | 1 | Adder can start an operation |
| add_go | output | 1 | Adder dispatch this cycle |
| add_tag | output | 3 | Tag of the entry sent to the adder |
| add_a | output | 16 | First operand to the adder |
| add_b | output | 16 | Second operand to the adder |
| mul_free | input | 2 | Per-multiplier free flags |
| mul_go | output | 2 | One-hot multiplier dispatch select |
| mul_tag | output | 3 | Tag of the entry sent to a multiplier |
| mul_a | output | 16 | First operand to the multiplier |
| mul_b | output | 16 | Second operand to the multiplier |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_tag | output | 3 | Tag of the retiring entry |
| commit_dst | output | 3 | Destination register written |
| commit_data | output | 16 | Value written to the register file |

## Verification
Several properties are checked on every cycle. The tail must hold still while the buffer refuses issue, and an accepted destination must be marked pending under the new tag. Result broadcasts may only target dispatched, unfinished entries. Concurrent adder and multiplier dispatches must pick different entries, and a multiplier select must be one-hot on a free unit. The head must advance by one per commit. Other behaviour is only visible through the bench's scenarios, which compare every dispatch and commit against an in-order reference. That reference covers which entry counts as oldest-ready, the operand values obtained through the three issue-time paths and later bus capture, the exact cycle an entry first becomes eligible, and the conditional clearing of a register's producer mark.

// File: rtl/unified_rs_rob.sv
module unified_rs_rob #(
  parameter int NENT  = 8,
  parameter int NREGS = 8,
  parameter int DW    = 16,
  parameter int NMUL  = 2,
  localparam int TW   = $clog2(NENT),
  localparam int RW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic            iss_cls,
  input  logic [RW-1:0]   iss_src1,
  input  logic [RW-1:0]   iss_src2,
  input  logic [RW-1:0]   iss_dst,
  output logic [TW-1:0]   iss_tag,
  input  logic            rb_valid,
  input  logic [TW-1:0]   rb_tag,
  input  logic [DW-1:0]   rb_data,
  input  logic            add_free,
  output logic            add_go,
  output logic [TW-1:0]   add_tag,
  output logic [DW-1:0]   add_a,
  output logic [DW-1:0]   add_b,
  input  logic [NMUL-1:0] mul_free,
  output logic [NMUL-1:0] mul_go,
  output logic [TW-1:0]   mul_tag,
  output logic [DW-1:0]   mul_a,
  output logic [DW-1:0]   mul_b,
  output logic            commit_valid,
  output logic [TW-1:0]   commit_tag,
  output logic [RW-1:0]   commit_dst,
  output logic [DW-1:0]   commit_data
);

  logic [TW:0]      head, tail;
  logic [TW-1:0]    hidx, tidx;
  logic             full, issue_fire;

  logic [NENT-1:0]  e_vld, e_cls, e_disp, e_done, e_r1, e_r2;
  logic [TW-1:0]    e_t1 [NENT];
  logic [TW-1:0]    e_t2 [NENT];
  logic [DW-1:0]    e_v1 [NENT];
  logic [DW-1:0]    e_v2 [NENT];
  logic [DW-1:0]    e_res[NENT];
  logic [RW-1:0]    e_dst[NENT];

  logic [DW-1:0]    rf   [NREGS];
  logic [NREGS-1:0] r_busy;
  logic [TW-1:0]    r_tag[NREGS];

  logic [DW+TW:0]   s1_rd, s2_rd;
  logic             a_found, m_found;
  logic [TW-1:0]    a_sel, m_sel;
  logic [NMUL-1:0]  m_pick;

  assign hidx       = head[TW-1:0];
  assign tidx       = tail[TW-1:0];
  assign full       = (head[TW] != tail[TW]) && (hidx == tidx);
  assign iss_ready  = !full;
  assign iss_tag    = tidx;
  assign issue_fire = iss_valid && !full;

  function automatic logic [DW+TW:0] rd_src(input logic [RW-1:0] s);
    logic [TW-1:0] p;
    p = r_tag[s];
    if (!r_busy[s])                    return {1'b1, {TW{1'b0}}, rf[s]};
    else if (e_done[p])                return {1'b1, p, e_res[p]};
    else if (rb_valid && rb_tag == p)  return {1'b1, p, rb_data};
    else                               return {1'b0, p, {DW{1'b0}}};
  endfunction

  assign s1_rd = rd_src(iss_src1);
  assign s2_rd = rd_src(iss_src2);

  always_comb begin : pick_oldest
    logic [TW-1:0] idx;
    logic          cand;
    a_found = 1'b0;
    m_found = 1'b0;
    a_sel   = '0;
    m_sel   = '0;
    for (int k = 0; k < NENT; k++) begin
      idx  = hidx + k[TW-1:0];
      cand = e_vld[idx] && !e_disp[idx] && e_r1[idx] && e_r2[idx];
      if (cand && !e_cls[idx] && !a_found) begin
        a_found = 1'b1;
        a_sel   = idx;
      end
      if (cand && e_cls[idx] && !m_found) begin
        m_found = 1'b1;
        m_sel   = idx;
      end
    end
  end

  assign m_pick  = mul_free & (~mul_free + 1'b1);

  assign add_go  = a_found && add_free;
  assign add_tag = a_sel;
  assign add_a   = e_v1[a_sel];
  assign add_b   = e_v2[a_sel];

  assign mul_go  = m_found ? m_pick : '0;
  assign mul_tag = m_sel;
  assign mul_a   = e_v1[m_sel];
  assign mul_b   = e_v2[m_sel];

  assign commit_valid = e_vld[hidx] && e_done[hidx];
  assign commit_tag   = hidx;
  assign commit_dst   = e_dst[hidx];
  assign commit_data  = e_res[hidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      e_vld  <= '0;
      e_cls  <= '0;
      e_disp <= '0;
      e_done <= '0;
      e_r1   <= '0;
      e_r2   <= '0;
      r_busy <= '0;
      for (int i = 0; i < NENT; i++) begin
        e_t1[i]  <= '0;
        e_t2[i]  <= '0;
        e_v1[i]  <= '0;
        e_v2[i]  <= '0;
        e_res[i] <= '0;
        e_dst[i] <= '0;
      end
      for (int r = 0; r < NREGS; r++) begin
        rf[r]    <= DW'(r);
        r_tag[r] <= '0;
      end
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (e_vld[i] && rb_valid) begin
          if (!e_r1[i] && e_t1[i] == rb_tag) begin
            e_r1[i] <= 1'b1;
            e_v1[i] <= rb_data;
          end
          if (!e_r2[i] && e_t2[i] == rb_tag) begin
            e_r2[i] <= 1'b1;
            e_v2[i] <= rb_data;
          end
          if (rb_tag == i[TW-1:0]) begin
            e_done[i] <= 1'b1;
            e_res[i]  <= rb_data;
          end
        end
      end

      if (add_go)       e_disp[a_sel] <= 1'b1;
      if (mul_go != '0) e_disp[m_sel] <= 1'b1;

      if (commit_valid) begin
        e_vld[hidx]      <= 1'b0;
        rf[e_dst[hidx]]  <= e_res[hidx];
        if (r_busy[e_dst[hidx]] && r_tag[e_dst[hidx]] == hidx)
          r_busy[e_dst[hidx]] <= 1'b0;
        head <= head + 1'b1;
      end

      if (issue_fire) begin
        e_vld[tidx]  <= 1'b1;
        e_cls[tidx]  <= iss_cls;
        e_dst[tidx]  <= iss_dst;
        e_disp[tidx] <= 1'b0;
        e_done[tidx] <= 1'b0;
        e_r1[tidx]   <= s1_rd[DW+TW];
        e_t1[tidx]   <= s1_rd[DW+TW-1:DW];
        e_v1[tidx]   <= s1_rd[DW-1:0];
        e_r2[tidx]   <= s2_rd[DW+TW];
        e_t2[tidx]   <= s2_rd[DW+TW-1:DW];
        e_v2[tidx]   <= s2_rd[DW-1:0];
        r_busy[iss_dst] <= 1'b1;
        r_tag[iss_dst]  <= tidx;
        tail <= tail + 1'b1;
      end
    end
  end

  p_hold_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |=> tail == $past(tail));

  p_dst_claimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> r_busy[$past(iss_dst)] && r_tag[$past(iss_dst)] == $past(tidx));

  p_bus_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> e_vld[rb_tag] && e_disp[rb_tag] && !e_done[rb_tag]);

  p_done_needs_disp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (e_vld & e_done & ~e_disp) == '0);

  p_distinct_entries_r7: assert property (@(posedge clk) disable iff (!rst_n)
    add_go && mul_go != '0 |-> add_tag != mul_tag);

  p_mul_onehot_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go != '0 |-> $countones(mul_go) == 1 && (mul_go & ~mul_free) == '0);

  p_head_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head == $past(head) + 1'b1);

endmodule

// File: tb/tb_unified_rs_rob.sv
module tb_unified_rs_rob;
  localparam int NENT = 8, NREGS = 8, DW = 16, NMUL = 2, TW = 3, RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            iss_valid = 0, iss_ready, iss_cls = 0;
  logic [RW-1:0]   iss_src1 = 0, iss_src2 = 0, iss_dst = 0;
  logic [TW-1:0]   iss_tag;
  logic            rb_valid = 0;
  logic [TW-1:0]   rb_tag = 0;
  logic [DW-1:0]   rb_data = 0;
  logic            add_free = 0, add_go;
  logic [TW-1:0]   add_tag, mul_tag, commit_tag;
  logic [DW-1:0]   add_a, add_b, mul_a, mul_b, commit_data;
  logic [NMUL-1:0] mul_free = 0, mul_go;
  logic            commit_valid;
  logic [RW-1:0]   commit_dst;

  unified_rs_rob dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cls(iss_cls),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_data(rb_data),
    .add_free(add_free), .add_go(add_go), .add_tag(add_tag), .add_a(add_a), .add_b(add_b),
    .mul_free(mul_free), .mul_go(mul_go), .mul_tag(mul_tag), .mul_a(mul_a), .mul_b(mul_b),
    .commit_valid(commit_valid), .commit_tag(commit_tag),
    .commit_dst(commit_dst), .commit_data(commit_data)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  bit            b_vld[NENT], b_cls[NENT], b_disp[NENT], b_dn[NENT], b_w1[NENT], b_w2[NENT];
  int            b_dst[NENT], b_p1[NENT], b_p2[NENT], b_rc1[NENT], b_rc2[NENT], b_isc[NENT], b_dnc[NENT];
  logic [DW-1:0] b_a[NENT], b_b[NENT], b_res[NENT];
  logic [DW-1:0] areg[NREGS];
  bit            m_busy[NREGS];
  int            m_stag[NREGS];
  int            head = 0, tail = 0, cnt = 0, cyc = 0;
  int            add_cnt = 0, add_own = 0;
  int            mul_cnt[NMUL], mul_own[NMUL];
  int            pq[$];

  function automatic logic [DW-1:0] calc(input bit cls, input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = a * b;
    return cls ? p[DW-1:0] : a + b;
  endfunction

  task automatic step(input bit allow_iss, input bit allow_free);
    int t, s1, s2, d, ea, em;
    bit exp_ag, exp_mg;
    logic [NMUL-1:0] pick;
    @(negedge clk);
    cyc++;
    if (add_cnt > 0) begin
      add_cnt--;
      if (add_cnt == 0) pq.push_back(add_own);
    end
    for (int m = 0; m < NMUL; m++)
      if (mul_cnt[m] > 0) begin
        mul_cnt[m]--;
        if (mul_cnt[m] == 0) pq.push_back(mul_own[m]);
      end

    rb_valid = 0;
    if (pq.size() > 0 && ($urandom % 4) != 0) begin
      t = pq.pop_front();
      rb_valid = 1;
      rb_tag   = t[TW-1:0];
      rb_data  = b_res[t];
      b_dn[t]  = 1;
      b_dnc[t] = cyc;
      for (int j = 0; j < NENT; j++) begin
        if (b_vld[j] && b_w1[j] && b_p1[j] == t) begin b_w1[j] = 0; b_rc1[j] = cyc; end
        if (b_vld[j] && b_w2[j] && b_p2[j] == t) begin b_w2[j] = 0; b_rc2[j] = cyc; end
      end
    end

    chk(iss_ready == (cnt < NENT), "R1 R6 iss_ready vs occupancy", iss_ready, cnt < NENT);
    iss_valid = allow_iss && ($urandom % 4) != 0;
    iss_cls   = $urandom % 2;
    s1 = $urandom % NREGS; s2 = $urandom % NREGS; d = $urandom % NREGS;
    iss_src1 = s1[RW-1:0]; iss_src2 = s2[RW-1:0]; iss_dst = d[RW-1:0];
    if (iss_valid && iss_ready) begin
      chk(iss_tag == tail, "R1 issue tag", iss_tag, tail);
      t = tail;
      b_w1[t] = m_busy[s1] && !b_dn[m_stag[s1]]; b_p1[t] = m_stag[s1]; b_rc1[t] = -1;
      b_w2[t] = m_busy[s2] && !b_dn[m_stag[s2]]; b_p2[t] = m_stag[s2]; b_rc2[t] = -1;
      b_a[t] = areg[s1];
      b_b[t] = areg[s2];
      b_res[t] = calc(iss_cls, b_a[t], b_b[t]);
      b_cls[t] = iss_cls; b_dst[t] = d;
      b_vld[t] = 1; b_disp[t] = 0; b_dn[t] = 0; b_isc[t] = cyc;
      areg[d] = b_res[t];
      m_busy[d] = 1; m_stag[d] = t;
      tail = (tail + 1) % NENT;
      cnt++;
    end else if (iss_valid) begin
      chk(iss_tag == tail, "R2 tag unchanged while full", iss_tag, tail);
    end

    add_free = allow_free && add_cnt == 0 && ($urandom % 4) != 0;
    for (int m = 0; m < NMUL; m++)
      mul_free[m] = allow_free && mul_cnt[m] == 0 && ($urandom % 4) != 0;

    #1;
    ea = -1; em = -1;
    for (int k = 0; k < NENT; k++) begin
      int j;
      j = (head + k) % NENT;
      if (b_vld[j] && !b_disp[j] && b_isc[j] < cyc && !b_w1[j] && b_rc1[j] < cyc
          && !b_w2[j] && b_rc2[j] < cyc) begin
        if (!b_cls[j] && ea < 0) ea = j;
        if (b_cls[j] && em < 0) em = j;
      end
    end

    exp_ag = (ea >= 0) && add_free;
    chk(add_go == exp_ag, "R5 R7 add_go", add_go, exp_ag);
    if (add_go && exp_ag) begin
      chk(add_tag == ea, "R7 oldest ready adder entry", add_tag, ea);
      chk(add_a == b_a[ea], "R3 R4 adder operand a", add_a, b_a[ea]);
      chk(add_b == b_b[ea], "R3 R4 adder operand b", add_b, b_b[ea]);
      b_disp[ea] = 1;
      add_cnt = 1 + $urandom % 4;
      add_own = ea;
    end

    pick = '0;
    for (int m = NMUL - 1; m >= 0; m--) if (mul_free[m]) begin pick = '0; pick[m] = 1'b1; end
    exp_mg = (em >= 0) && (mul_free != '0);
    chk(mul_go == (exp_mg ? pick : '0), "R8 multiplier select", mul_go, exp_mg ? pick : 0);
    if (exp_mg && mul_go == pick) begin
      chk(mul_tag == em, "R8 oldest ready multiplier entry", mul_tag, em);
      chk(mul_a == b_a[em], "R3 R4 multiplier operand a", mul_a, b_a[em]);
      chk(mul_b == b_b[em], "R3 R4 multiplier operand b", mul_b, b_b[em]);
      b_disp[em] = 1;
      for (int m = 0; m < NMUL; m++)
        if (pick[m]) begin mul_cnt[m] = 1 + $urandom % 5; mul_own[m] = em; end
    end

    begin
      bit exp_cv;
      exp_cv = cnt > 0 && b_vld[head] && b_dn[head] && b_dnc[head] < cyc;
      chk(commit_valid == exp_cv, "R9 commit_valid", commit_valid, exp_cv);
      if (exp_cv && commit_valid) begin
        chk(commit_tag == head, "R9 commit order", commit_tag, head);
        chk(commit_dst == b_dst[head], "R9 commit destination", commit_dst, b_dst[head]);
        chk(commit_data == b_res[head], "R9 commit data", commit_data, b_res[head]);
        d = b_dst[head];
        if (m_busy[d] && m_stag[d] == head) m_busy[d] = 0;
        b_vld[head] = 0;
        head = (head + 1) % NENT;
        cnt--;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREGS; r++) begin areg[r] = DW'(r); m_busy[r] = 0; m_stag[r] = 0; end
    for (int m = 0; m < NMUL; m++) begin mul_cnt[m] = 0; mul_own[m] = 0; end
    for (int e = 0; e < NENT; e++) begin
      b_vld[e] = 0; b_dn[e] = 0; b_disp[e] = 0; b_w1[e] = 0; b_w2[e] = 0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    add_free = 1; mul_free = '1;
    #1;
    chk(iss_ready == 1, "R10 reset iss_ready", iss_ready, 1);
    chk(iss_tag == 0, "R10 reset tag", iss_tag, 0);
    chk(commit_valid == 0, "R10 reset commit", commit_valid, 0);
    chk(add_go == 0, "R10 reset adder dispatch", add_go, 0);
    chk(mul_go == 0, "R10 reset multiplier dispatch", mul_go, 0);
    add_free = 0; mul_free = '0;
    rst_n = 1;

    repeat (30) step(1, 0);
    repeat (4000) step(1, 1);
    repeat (60) step(1, 0);
    repeat (2000) step(1, 1);
    begin
      int guard;
      guard = 0;
      while (cnt > 0 && guard < 2000) begin step(0, 1); guard++; end
      chk(cnt == 0, "R9 buffer drains", cnt, 0);
    end
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule